// File: doc/BRIEF.md
# Windowed Graphics RAM Write Addresser

This block turns a stream of pixel bytes from a host into write addresses for a graphics RAM that is 16 byte-columns wide and 40 rows tall. Each byte holds eight horizontally adjacent pixels. Before a burst, the host sets a rectangular window and a direction code, then pulses `restart`. The pulse corresponds to the host issuing the data command. Each byte that follows, marked by `din_valid`, is placed at the current cursor and the cursor moves one step through the window.

The direction code has three jobs. It selects the corner the walk starts from. It selects whether the column or the row index moves fastest. It selects whether the pixel order inside each byte is reversed. When the cursor has written the final cell of the window, the block raises `done` and ignores all further bytes until the next restart. The cursor never wraps back into the window and never leaves it.

Top module: `gwa_window_addresser`

## Requirements
- R1: After reset `ram_we` and `done` are 0. Data strobes are ignored, so `ram_we` stays 0, until the first `restart`.
- R2: `restart` places the cursor on a window corner chosen by `dir_code[1:0]`. The corners are 0 = (x_lo,y_lo), 1 = (x_hi,y_lo), 2 = (x_lo,y_hi) and 3 = (x_hi,y_hi). `dir_code[0]`=1 makes X descend and `dir_code[1]`=1 makes Y descend.
- R3: With `dir_code[2]`=0, X is the fast axis. When X passes its far bound it reloads its start bound and Y takes one step.
- R4: With `dir_code[2]`=1, Y is the fast axis. When Y passes its far bound it reloads its start bound and X takes one step.
- R5: With `dir_code[3]`=0, `ram_wdata` equals `din`, with bit 7 as the first pixel. With `dir_code[3]`=1, `ram_wdata` is `din` bit-reversed, so that `din` bit 0 lands on bit 7.
- R6: An accepted byte appears on `ram_we`/`ram_x`/`ram_y`/`ram_wdata` in the cycle after its strobe, for exactly one cycle. The address always lies inside the window.
- R7: `done` rises in the same cycle as the write of the window's final cell. While `done` is 1, strobes cause no write.
- R8: `restart` clears `done` and returns the cursor to the start corner. This holds also in the middle of a burst.
- R9: A strobe in the same cycle as `restart` is dropped.
- R10: Window bounds and the direction code are sampled only at `restart`. Changing them later has no effect on the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_x_lo | input | 4 | Window first byte-column |
| win_x_hi | input | 4 | Window last byte-column |
| win_y_lo | input | 6 | Window first row |
| win_y_hi | input | 6 | Window last row |
| dir_code | input | 4 | Walk direction and bit order code |
| restart | input | 1 | Burst start pulse |
| din_valid | input | 1 | Data byte strobe |
| din | input | 8 | Pixel byte |
| ram_we | output | 1 | RAM write enable |
| ram_x | output | 4 | RAM byte-column address |
| ram_y | output | 6 | RAM row address |
| ram_wdata | output | 8 | Bit-ordered write data |
| done | output | 1 | Window fully written |

## Verification
The range assertions assume that each window has its low bound at or below its high bound. They also assume the bounds lie within the RAM (column 0 to 15, row 0 to 39), because an inverted or oversized window has no defined walk. Every window the stimulus loads, whether from the vector table or in the directed tests, meets both conditions. This includes single-cell windows and the full-RAM window. Bounds are changed only after a restart has captured them, so the cursor stays inside the box under test.

// File: rtl/gwa_pkg.sv
// Shared widths and the direction-code decode for the window addresser.
// Assumes a 4-bit direction code; bit meanings are fixed here only.
package gwa_pkg;

    localparam int GWA_CODE_W = 4;

    // Decoded walk order
    typedef struct packed {
        logic bit_rev;     // code bit 3: reverse pixel order in byte
        logic vert_first;  // code bit 2: Y is the fast axis
        logic row_up;      // code bit 1: Y descends
        logic col_left;    // code bit 0: X descends
    } gwa_order_t;

    function automatic gwa_order_t gwa_decode(input logic [GWA_CODE_W-1:0] code);
        gwa_order_t o;
        o.col_left   = code[0];
        o.row_up     = code[1];
        o.vert_first = code[2];
        o.bit_rev    = code[3];
        return o;
    endfunction

endpackage

// File: rtl/gwa_axis_walker.sv
// One axis of the cursor: captures its bounds and direction at load and
// steps toward the far bound, reloading the start bound after the far one.
// Assumes lo <= hi at load time.
module gwa_axis_walker #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic         descend,
    input  logic         step,
    output logic [W-1:0] pos,
    output logic         at_far
);

    logic [W-1:0] lo_q, hi_q, pos_q;
    logic         desc_q;
    logic [W-1:0] start_b, far_b;

    // Start and far bound for the captured direction
    always_comb begin
        start_b = desc_q ? hi_q : lo_q;
        far_b   = desc_q ? lo_q : hi_q;
    end

    assign at_far = (pos_q == far_b);
    assign pos    = pos_q;

    // Bound capture and position stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            desc_q <= 1'b0;
            pos_q  <= '0;
        end else if (load) begin
            lo_q   <= lo;
            hi_q   <= hi;
            desc_q <= descend;
            pos_q  <= descend ? hi : lo;
        end else if (step) begin
            if (at_far)      pos_q <= start_b;
            else if (desc_q) pos_q <= pos_q - 1'b1;
            else             pos_q <= pos_q + 1'b1;
        end
    end

    AST_AXIS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q >= lo_q) && (pos_q <= hi_q)); // R6
    AST_AXIS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(pos_q)); // R3
    AST_AXIS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step && at_far) |=> (pos_q == $past(start_b))); // R4

endmodule

// File: rtl/gwa_walk_ctrl.sv
// Burst control: arms on restart, accepts strobes while armed, routes the
// step to the fast axis and the wrap to the slow axis, and ends the burst
// at the final window cell. Restart overrides a same-cycle strobe.
module gwa_walk_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic din_valid,
    input  logic vert_first,
    input  logic x_far,
    input  logic y_far,
    output logic accept,
    output logic step_x,
    output logic step_y,
    output logic done
);

    logic armed_q, done_q, vf_q;
    logic fast_far, last_cell;

    // Acceptance and axis step routing
    always_comb begin
        accept    = din_valid && armed_q && !restart;
        fast_far  = vf_q ? y_far : x_far;
        last_cell = x_far && y_far;
        step_x    = accept && (vf_q ? y_far : 1'b1);
        step_y    = accept && (vf_q ? 1'b1 : x_far);
    end

    assign done = done_q;

    // Burst state: armed until the final cell is written
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            done_q  <= 1'b0;
            vf_q    <= 1'b0;
        end else if (restart) begin
            armed_q <= 1'b1;
            done_q  <= 1'b0;
            vf_q    <= vert_first;
        end else if (accept && last_cell) begin
            armed_q <= 1'b0;
            done_q  <= 1'b1;
        end
    end

    AST_NO_ACCEPT_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !accept); // R7
    AST_RESTART_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !done_q); // R8
    AST_SLOW_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_x && step_y) |-> fast_far); // R3
    AST_DROP_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> !step_x && !step_y); // R9

endmodule

// File: rtl/gwa_bit_order.sv
// Pixel order selector: passes the byte through or mirrors its bits.
// Purely combinational.
module gwa_bit_order #(
    parameter int DW = 8
) (
    input  logic          rev,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    // One mux per bit position
    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign dout[i] = rev ? din[DW-1-i] : din[i];
    end

endmodule

// File: rtl/gwa_window_addresser.sv
// Top: captures window and direction at restart, walks a cursor through
// the window one cell per accepted byte and registers the RAM write.
// Assumes lo <= hi on both axes and bounds inside the RAM.
module gwa_window_addresser
    import gwa_pkg::*;
#(
    parameter int XW     = 4,
    parameter int YW     = 6,
    parameter int DW     = 8,
    parameter int X_LAST = 15,
    parameter int Y_LAST = 39
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [XW-1:0]         win_x_lo,
    input  logic [XW-1:0]         win_x_hi,
    input  logic [YW-1:0]         win_y_lo,
    input  logic [YW-1:0]         win_y_hi,
    input  logic [GWA_CODE_W-1:0] dir_code,
    input  logic                  restart,
    input  logic                  din_valid,
    input  logic [DW-1:0]         din,
    output logic                  ram_we,
    output logic [XW-1:0]         ram_x,
    output logic [YW-1:0]         ram_y,
    output logic [DW-1:0]         ram_wdata,
    output logic                  done
);

    gwa_order_t    ord;
    logic          rev_q;
    logic [XW-1:0] cur_x;
    logic [YW-1:0] cur_y;
    logic          x_far, y_far;
    logic          accept, step_x, step_y;
    logic [DW-1:0] ordered;

    assign ord = gwa_decode(dir_code);

    gwa_axis_walker #(.W(XW)) u_xaxis (
        .clk(clk), .rst_n(rst_n), .load(restart),
        .lo(win_x_lo), .hi(win_x_hi), .descend(ord.col_left),
        .step(step_x), .pos(cur_x), .at_far(x_far)
    );

    gwa_axis_walker #(.W(YW)) u_yaxis (
        .clk(clk), .rst_n(rst_n), .load(restart),
        .lo(win_y_lo), .hi(win_y_hi), .descend(ord.row_up),
        .step(step_y), .pos(cur_y), .at_far(y_far)
    );

    gwa_walk_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .restart(restart), .din_valid(din_valid),
        .vert_first(ord.vert_first), .x_far(x_far), .y_far(y_far),
        .accept(accept), .step_x(step_x), .step_y(step_y), .done(done)
    );

    gwa_bit_order #(.DW(DW)) u_order (
        .rev(rev_q), .din(din), .dout(ordered)
    );

    // Bit order captured at restart
    always_ff @(posedge clk) begin
        if (!rst_n)       rev_q <= 1'b0;
        else if (restart) rev_q <= ord.bit_rev;
    end

    // Registered RAM write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we    <= 1'b0;
            ram_x     <= '0;
            ram_y     <= '0;
            ram_wdata <= '0;
        end else begin
            ram_we <= accept;
            if (accept) begin
                ram_x     <= cur_x;
                ram_y     <= cur_y;
                ram_wdata <= ordered;
            end
        end
    end

    AST_WE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(din_valid) && !$past(restart)); // R9
    AST_WE_IN_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (int'(ram_x) <= X_LAST) && (int'(ram_y) <= Y_LAST)); // R6
    AST_DONE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ram_we); // R7
    AST_NO_WRITE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !restart) |=> !ram_we); // R7

endmodule

// File: tb/sim_gwa_window_addresser.sv
`timescale 1ns/1ps
module sim_gwa_window_addresser;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] win_x_lo = '0, win_x_hi = 4'd15;
    logic [5:0] win_y_lo = '0, win_y_hi = 6'd39;
    logic [3:0] dir_code = '0;
    logic       restart = 1'b0, din_valid = 1'b0;
    logic [7:0] din = '0;
    logic       ram_we, done;
    logic [3:0] ram_x;
    logic [5:0] ram_y;
    logic [7:0] ram_wdata;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    gwa_window_addresser u0 (
        .clk(clk), .rst_n(rst_n), .win_x_lo(win_x_lo), .win_x_hi(win_x_hi),
        .win_y_lo(win_y_lo), .win_y_hi(win_y_hi), .dir_code(dir_code),
        .restart(restart), .din_valid(din_valid), .din(din),
        .ram_we(ram_we), .ram_x(ram_x), .ram_y(ram_y),
        .ram_wdata(ram_wdata), .done(done)
    );

    // {dir, x_lo, x_hi, y_lo, y_hi}
    localparam logic [23:0] VEC [8] = '{
        {4'h0, 4'd2,  4'd5,  6'd3,  6'd6},
        {4'h1, 4'd2,  4'd5,  6'd3,  6'd6},
        {4'h2, 4'd2,  4'd5,  6'd3,  6'd6},
        {4'h3, 4'd2,  4'd5,  6'd3,  6'd6},
        {4'h4, 4'd0,  4'd2,  6'd10, 6'd14},
        {4'h7, 4'd13, 4'd15, 6'd35, 6'd39},
        {4'h8, 4'd7,  4'd7,  6'd0,  6'd0},
        {4'hE, 4'd1,  4'd4,  6'd20, 6'd21}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    task automatic set_win(input logic [3:0] d, input logic [3:0] xl, input logic [3:0] xh,
                           input logic [5:0] yl, input logic [5:0] yh);
        @(negedge clk);
        dir_code = d; win_x_lo = xl; win_x_hi = xh; win_y_lo = yl; win_y_hi = yh;
    endtask

    task automatic do_restart();
        @(negedge clk); restart = 1'b1;
        @(negedge clk); restart = 1'b0;
    endtask

    // Present one byte; outputs sampled 1 ns after the capturing edge
    task automatic push(input logic [7:0] b);
        @(negedge clk); din_valid = 1'b1; din = b;
        @(posedge clk); #1;
        @(negedge clk); din_valid = 1'b0;
        #0;
    endtask

    // Expected cell for byte k of a burst
    task automatic exp_cell(input int k, input logic [3:0] d, input int xl, input int xh,
                            input int yl, input int yh, output int ex, output int ey);
        int nx, ny, fi, si;
        nx = xh - xl + 1; ny = yh - yl + 1;
        if (d[2]) begin
            fi = k % ny; si = k / ny;
            ey = d[1] ? yh - fi : yl + fi;
            ex = d[0] ? xh - si : xl + si;
        end else begin
            fi = k % nx; si = k / nx;
            ex = d[0] ? xh - fi : xl + fi;
            ey = d[1] ? yh - si : yl + si;
        end
    endtask

    // Push one byte and compare the write it produces (sampled before negedge)
    task automatic push_chk(input logic [7:0] b, input int ex, input int ey, input logic rv,
                            input logic exp_done, input string tag);
        @(negedge clk); din_valid = 1'b1; din = b;
        @(posedge clk); #1;
        chk({tag, " R6 we"}, 32'(ram_we), 32'd1);
        chk({tag, " x"}, 32'(ram_x), 32'(ex));
        chk({tag, " y"}, 32'(ram_y), 32'(ey));
        chk("R5 data", 32'(ram_wdata), 32'(rv ? rev8(b) : b));
        chk("R7 done", 32'(done), 32'(exp_done));
        @(negedge clk); din_valid = 1'b0;
    endtask

    task automatic push_ignored(input string tag);
        @(negedge clk); din_valid = 1'b1; din = 8'h5A;
        @(posedge clk); #1;
        chk(tag, 32'(ram_we), 32'd0);
        @(negedge clk); din_valid = 1'b0;
    endtask

    initial begin : watchdog
        #(4 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int ex, ey, total;
        logic [3:0] d, xl, xh;
        logic [5:0] yl, yh;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 we in reset", 32'(ram_we), 32'd0);
        chk("R1 done in reset", 32'(done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", 32'(done), 32'd0);
        push_ignored("R1 strobe before restart");

        // Vector table walk: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < 8; v++) begin
            {d, xl, xh, yl, yh} = VEC[v];
            set_win(d, xl, xh, yl, yh);
            do_restart();
            total = (int'(xh) - int'(xl) + 1) * (int'(yh) - int'(yl) + 1);
            for (int k = 0; k < total; k++) begin
                exp_cell(k, d, int'(xl), int'(xh), int'(yl), int'(yh), ex, ey);
                push_chk(8'(k * 37 + v * 11 + 1), ex, ey, d[3], k == total - 1,
                         k == 0 ? "R2 corner" : (d[2] ? "R4 walk" : "R3 walk"));
            end
            push_ignored("R7 byte after done");
            chk("R7 done held", 32'(done), 32'd1);
        end

        // R8: restart clears done, and mid-burst restart returns to corner
        set_win(4'h0, 4'd0, 4'd3, 6'd0, 6'd1);
        do_restart();
        chk("R8 done cleared", 32'(done), 32'd0);
        push_chk(8'h11, 0, 0, 1'b0, 1'b0, "R8 first");
        push_chk(8'h22, 1, 0, 1'b0, 1'b0, "R8 second");
        do_restart();
        push_chk(8'h33, 0, 0, 1'b0, 1'b0, "R8 back to corner");

        // R9: strobe coinciding with restart is dropped
        set_win(4'h3, 4'd4, 4'd6, 6'd8, 6'd9);
        @(negedge clk); restart = 1'b1; din_valid = 1'b1; din = 8'hEE;
        @(posedge clk); #1;
        @(negedge clk); restart = 1'b0; din_valid = 1'b0;
        chk("R9 no write with restart", 32'(ram_we), 32'd0);
        push_chk(8'h44, 6, 9, 1'b0, 1'b0, "R9 corner kept");

        // R10: bounds changed after restart do not affect the burst
        set_win(4'h0, 4'd9, 4'd10, 6'd30, 6'd30);
        do_restart();
        set_win(4'hF, 4'd0, 4'd15, 6'd0, 6'd39);
        push_chk(8'h81, 9, 30, 1'b0, 1'b0, "R10 cell0");
        push_chk(8'h82, 10, 30, 1'b0, 1'b1, "R10 cell1");
        push_ignored("R10 burst ended");

        // Full RAM window, default bounds, forward walk
        set_win(4'h0, 4'd0, 4'd15, 6'd0, 6'd39);
        do_restart();
        for (int k = 0; k < 640; k++)
            push_chk(8'(k), k % 16, k / 16, 1'b0, k == 639, "R3 full");
        push_ignored("R7 full done");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule